// File: doc/BRIEF.md
# Shared Core Clock-Modulation Controller

This block generates the clock-enable pulse train for one execution core that is shared by several hardware threads, two by default. Each thread has its own software request: an enable bit and a 3-bit duty code. The block merges these requests with two sensor flags. One flag is a thermal-trip indication that throttles the whole core. The other is a catastrophic over-temperature indication that stops the core for good. The result is a single enable that a downstream clock gate consumes. A halt indication is raised when the core has been stopped.

Time is divided into 8-cycle windows by a free-running counter. In each window the enable is high for the first n cycles, where n is the duty code in force for that window. A new duty code is only taken at a window boundary, so the gate never sees a shortened high or low phase. As a side function, the block combines the per-thread cache-disable bits into one disable for the shared cache.

Top module: `core_clk_mod_ctrl`

## Requirements
- R1: With no thread requesting modulation and the thermal-trip flag low, `core_clk_en` is 1 on every cycle.
- R2: A duty code n from 1 to 7 in force for a window makes `core_clk_en` 1 in window positions 0 to n-1 and 0 in positions n to 7. Thread i's enable is `thr_mod_en[i]`, and its code is `thr_duty[3*i+2:3*i]`.
- R3: A thread whose code is 0, or whose enable bit is 0, contributes no modulation request.
- R4: When several threads request modulation, the largest requested code is the one applied.
- R5: While `therm_trip` is 1 the core is modulated at code 4, whatever the software requests. If a thread requests a smaller nonzero code, that smaller code applies instead.
- R6: The code in force is sampled only in window position 7 and applies from the next position 0. A change in the middle of a window does not alter the rest of that window.
- R7: `crit_temp` at 1 on a clock edge sets `core_halt` to 1 and `core_clk_en` to 0 from the next cycle. Both stay that way until reset, even after `crit_temp` returns to 0.
- R8: `cache_disable` is 1 whenever any bit of `thr_cache_dis` is 1, in the same cycle.
- R9: Reset clears the halt, cancels modulation, and restarts the window at position 0. The window starts on the second clock edge after `rst_n` rises and runs its position 0 in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| thr_mod_en | input | NUM_THREADS | Per-thread software modulation enable |
| thr_duty | input | NUM_THREADS*DUTY_W | Per-thread duty codes, thread i in bits [DUTY_W*i +: DUTY_W] |
| thr_cache_dis | input | NUM_THREADS | Per-thread cache-disable bits |
| therm_trip | input | 1 | Automatic thermal-trip flag |
| crit_temp | input | 1 | Catastrophic over-temperature flag |
| core_clk_en | output | 1 | Clock enable for the shared core |
| core_halt | output | 1 | Sticky halt indication |
| cache_disable | output | 1 | Merged cache disable |

## Verification
The hardest case to reach from the ports is a request that changes in the middle of a window. Because the window counter cannot be read, the bench tracks window positions itself, counting from the known release point of reset. This lets it change the request at a chosen position and show that the old pattern finishes the window. The full sweep covers every combination of enables, codes and thermal flag for two threads. Each window pattern is compared against an arithmetic model. Halt stickiness is checked by dropping `crit_temp` and watching the outputs over many windows.

// File: rtl/cm_pkg.sv
package cm_pkg;

  // Origin of the modulation code chosen for a window.
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SW    = 2'd1,
    SRC_THERM = 2'd2
  } mod_src_e;

  localparam int DEF_THREADS    = 2;
  localparam int DEF_DUTY_W     = 3;
  localparam int DEF_THERM_DUTY = 4;

endpackage

// File: rtl/cm_rst_sync.sv
module cm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= sh_d;
  end

  assign rst_n_out = sh_q[STAGES-1];

endmodule

// File: rtl/cm_duty_merge.sv
module cm_duty_merge
  import cm_pkg::*;
#(
  parameter int NUM_THREADS = DEF_THREADS,
  parameter int DUTY_W      = DEF_DUTY_W,
  parameter int THERM_DUTY  = DEF_THERM_DUTY
) (
  input  logic [NUM_THREADS-1:0]        thr_en,
  input  logic [NUM_THREADS*DUTY_W-1:0] thr_code,
  input  logic                          therm_trip,
  output logic [DUTY_W-1:0]             req_code
);

  localparam logic [DUTY_W-1:0] THERM_CODE = DUTY_W'(THERM_DUTY);

  logic [DUTY_W-1:0] sw_max;
  logic [DUTY_W-1:0] cand;
  mod_src_e          src;

  // Largest code among enabled threads; a zero code adds nothing.
  always_comb begin
    sw_max = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      cand = thr_en[i] ? thr_code[i*DUTY_W +: DUTY_W] : '0;
      if (cand > sw_max) sw_max = cand;
    end
  end

  // The thermal floor replaces software unless software is more aggressive.
  always_comb begin
    if (therm_trip && !((sw_max != '0) && (sw_max < THERM_CODE))) src = SRC_THERM;
    else if (sw_max != '0)                                         src = SRC_SW;
    else                                                           src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_THERM: req_code = THERM_CODE;
      SRC_SW:    req_code = sw_max;
      default:   req_code = '0;
    endcase
  end

endmodule

// File: rtl/cm_window_gen.sv
module cm_window_gen #(
  parameter int DUTY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] req_code,
  input  logic              halt,
  output logic              clk_en,
  output logic [DUTY_W-1:0] win_cnt,
  output logic [DUTY_W-1:0] act_duty
);

  logic [DUTY_W-1:0] cnt_q, cnt_d;
  logic [DUTY_W-1:0] act_q, act_d;
  logic              win_last;

  always_comb begin
    win_last = &cnt_q;
    cnt_d    = cnt_q + 1'b1;
    act_d    = win_last ? req_code : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign clk_en   = ~halt & ((act_q == '0) | (cnt_q < act_q));
  assign win_cnt  = cnt_q;
  assign act_duty = act_q;

endmodule

// File: rtl/cm_halt_latch.sv
module cm_halt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic crit,
  output logic halt
);

  logic halt_q, halt_d;

  always_comb begin
    halt_d = halt_q | crit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_d;
  end

  assign halt = halt_q;

endmodule

// File: rtl/core_clk_mod_ctrl.sv
module core_clk_mod_ctrl
  import cm_pkg::*;
#(
  parameter int NUM_THREADS = DEF_THREADS,
  parameter int DUTY_W      = DEF_DUTY_W,
  parameter int THERM_DUTY  = DEF_THERM_DUTY,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THREADS-1:0]        thr_mod_en,
  input  logic [NUM_THREADS*DUTY_W-1:0] thr_duty,
  input  logic [NUM_THREADS-1:0]        thr_cache_dis,
  input  logic                          therm_trip,
  input  logic                          crit_temp,
  output logic                          core_clk_en,
  output logic                          core_halt,
  output logic                          cache_disable
);

  logic              rst_sync_n;
  logic [DUTY_W-1:0] req_code;
  logic [DUTY_W-1:0] win_cnt;
  logic [DUTY_W-1:0] act_duty;

  cm_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  cm_duty_merge #(
    .NUM_THREADS (NUM_THREADS),
    .DUTY_W      (DUTY_W),
    .THERM_DUTY  (THERM_DUTY)
  ) i_merge (
    .thr_en     (thr_mod_en),
    .thr_code   (thr_duty),
    .therm_trip (therm_trip),
    .req_code   (req_code)
  );

  cm_halt_latch i_halt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .crit  (crit_temp),
    .halt  (core_halt)
  );

  cm_window_gen #(.DUTY_W(DUTY_W)) i_win (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_code (req_code),
    .halt     (core_halt),
    .clk_en   (core_clk_en),
    .win_cnt  (win_cnt),
    .act_duty (act_duty)
  );

  assign cache_disable = |thr_cache_dis;

endmodule

// File: rtl/cm_checker.sv
module cm_checker #(
  parameter int DUTY_W = 3
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              crit_temp,
  input logic              core_halt,
  input logic              core_clk_en,
  input logic [DUTY_W-1:0] win_cnt,
  input logic [DUTY_W-1:0] act_duty
);

  assert_crit_halts_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    crit_temp |=> core_halt);

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    core_halt |=> core_halt);

  assert_halt_gates_clock_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    core_halt |-> !core_clk_en);

  assert_code_held_in_window_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (win_cnt != '0) |-> $stable(act_duty));

endmodule

bind core_clk_mod_ctrl cm_checker #(.DUTY_W(DUTY_W)) i_cm_checker (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .crit_temp   (crit_temp),
  .core_halt   (core_halt),
  .core_clk_en (core_clk_en),
  .win_cnt     (win_cnt),
  .act_duty    (act_duty)
);

// File: tb/test_core_clk_mod_ctrl.sv
`timescale 1ns/1ps
module test_core_clk_mod_ctrl;

  localparam int CLK_NS = 20;

  logic       clk;
  logic       rst_n;
  logic [1:0] thr_mod_en;
  logic [5:0] thr_duty;
  logic [1:0] thr_cache_dis;
  logic       therm_trip;
  logic       crit_temp;
  logic       core_clk_en;
  logic       core_halt;
  logic       cache_disable;

  int total;
  int bad;
  logic       run;
  logic [2:0] ph;

  core_clk_mod_ctrl i_core_clk_mod_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .thr_mod_en    (thr_mod_en),
    .thr_duty      (thr_duty),
    .thr_cache_dis (thr_cache_dis),
    .therm_trip    (therm_trip),
    .crit_temp     (crit_temp),
    .core_clk_en   (core_clk_en),
    .core_halt     (core_halt),
    .cache_disable (cache_disable)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  // Bench-side window position model.
  always @(posedge clk) begin
    if (!run) ph <= 3'd0;
    else      ph <= ph + 3'd1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_code(input logic [1:0] en, input logic [5:0] d, input logic th);
    int sw;
    int c;
    sw = 0;
    for (int i = 0; i < 2; i++) begin
      c = int'(d[3*i +: 3]);
      if (en[i] && c > sw) sw = c;
    end
    if (th && !(sw != 0 && sw < 4)) return 4;
    return sw;
  endfunction

  function automatic logic [7:0] model_pattern(input int code);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = (code == 0) || (i < code);
    return p;
  endfunction

  task automatic do_reset();
    run   = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 halt in reset", int'(core_halt), 0);
    chk("R9 clk_en in reset", int'(core_clk_en), 1);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 run = 1'b1;
    @(negedge clk);
  endtask

  // Waits for position 7, then records the next full window.
  task automatic check_window(input string tag, input int code);
    logic [7:0] got;
    while (ph != 3'd7) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      got[i] = core_clk_en;
    end
    chk(tag, int'(got), int'(model_pattern(code)));
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad = 0;
    run = 1'b0;
    rst_n = 1'b0;
    thr_mod_en = '0;
    thr_duty = '0;
    thr_cache_dis = '0;
    therm_trip = 1'b0;
    crit_temp = 1'b0;

    do_reset();

    // R1: idle, every cycle enabled.
    check_window("R1 idle", 0);

    // Sweep every request combination.
    for (int th = 0; th < 2; th++) begin
      for (int en = 0; en < 4; en++) begin
        for (int d0 = 0; d0 < 8; d0++) begin
          for (int d1 = 0; d1 < 8; d1++) begin
            string tag;
            int code;
            thr_mod_en    = 2'(en);
            thr_duty      = {3'(d1), 3'(d0)};
            therm_trip    = th[0];
            thr_cache_dis = 2'(d0 + d1);
            #1;
            chk("R8 cache or", int'(cache_disable), int'(|thr_cache_dis));
            code = model_code(thr_mod_en, thr_duty, therm_trip);
            if (th != 0)                        tag = "R5 thermal";
            else if (en == 3 && d0 != 0 && d1 != 0) tag = "R4 largest";
            else if (code == 0)                 tag = "R3 no request";
            else                                tag = "R2 single";
            check_window(tag, code);
          end
        end
      end
    end

    // R6: change in mid-window must not shorten the running window.
    therm_trip = 1'b0;
    thr_mod_en = 2'b01;
    thr_duty   = {3'd0, 3'd2};
    check_window("R6 before change", 2);
    while (ph != 3'd3) @(negedge clk);
    thr_duty = {3'd0, 3'd6};
    begin
      logic [3:0] tail;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        tail[i] = core_clk_en;
      end
      chk("R6 tail of old window", int'(tail), 0);
    end
    check_window("R6 after boundary", 6);

    // R7: sticky halt.
    @(negedge clk);
    crit_temp = 1'b1;
    @(negedge clk);
    chk("R7 halt set", int'(core_halt), 1);
    chk("R7 clk_en low", int'(core_clk_en), 0);
    crit_temp = 1'b0;
    thr_mod_en = 2'b00;
    begin
      int highs;
      int nohalt;
      highs = 0;
      nohalt = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (core_clk_en) highs++;
        if (!core_halt) nohalt++;
      end
      chk("R7 clk_en stays low", highs, 0);
      chk("R7 halt stays", nohalt, 0);
    end

    // R9: reset clears halt, phase restarts.
    do_reset();
    chk("R9 halt cleared", int'(core_halt), 0);
    chk("R9 clk_en after reset", int'(core_clk_en), 1);
    therm_trip = 1'b1;
    check_window("R9 phase after reset", 4);
    chk("R8 cache none", int'(cache_disable), int'(|thr_cache_dis));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule